// File: doc/BRIEF.md
# Repeated string operation sequencer

This unit executes one string instruction for a processor core. Seven operations are covered: block move, block compare, store from the accumulator, load into the accumulator, scan against the accumulator, port input to memory and memory output to a port. Each runs at byte, word or doubleword element size, either once or under a repeat prefix that runs unconditionally, while elements are equal, or while they differ. The core hands over its pointer, count, accumulator, port and flag state through a valid/ready start interface. When the instruction ends, the unit hands back the updated state with a one-cycle done pulse.

Memory and port traffic goes out as one request at a time on a valid/ready channel. A request with `mreq_valid` high keeps its address, kind, size and write data unchanged until the cycle in which `mreq_ready` is high. Read data is taken from `mreq_rdata` in that same cycle. The environment can stall any request for as long as it needs. Translation faults are outside the unit and reach it only as `abort_i`.

Top module: `strop_seq`

## Requirements
- R1: `start_ready` is high only while the unit is idle. A start is taken on `start_valid && start_ready`. Every instruction ends with `done_o` high for exactly one cycle, and nothing is issued while idle.
- R2: Element size code 0/1/2 means 1/2/4 bytes. After each element, every pointer the operation uses moves by +size when `dir_i`=0 and by -size when `dir_i`=1. Move, compare, load and port output (op codes 0, 1, 3, 6) use the source pointer. Move, compare, store, scan and port input (op codes 0, 1, 2, 4, 5) use the destination pointer. An unused pointer is returned unchanged.
- R3: With `addr32_i`=0, only the low 16 bits of each pointer and of the count are stepped, and they wrap at 0xFFFF. The upper 16 bits come back unchanged, and memory addresses are issued with the upper 16 bits zero. With `addr32_i`=1 the full 32 bits are used.
- R4: With a repeat prefix (rep code 1 or 2), a count that is zero in the active address size issues no request, changes no returned value and ends with done and no fault.
- R5: Under a repeat prefix the count drops by one per element and the instruction ends when it reaches zero. Without a prefix (rep code 0) exactly one element runs and the count is returned unchanged.
- R6: For compare and scan, rep code 1 also ends the instruction after the first element whose two values differ. Rep code 2 also ends it after the first element whose two values are equal.
- R7: Move, store, load, port input and port output ignore the equal/differ condition. Under either prefix they stop only when the count is exhausted, and memory holds exactly the writes of the completed elements.
- R8: Compare and scan set the flags from the final element only, as source element minus destination element at operand size. Bit 0 is carry (unsigned borrow), bit 1 is zero, bit 2 is sign and bit 3 is overflow. The flags change at no other time than start and done, and other operations return `flags_i` unchanged.
- R9: Store and scan use the accumulator masked to the element size as the source element. Load writes each fetched element into the low byte, the low word or the whole accumulator, and keeps the other bits.
- R10: Port input reads and port output writes at the address `port_i`, with `mreq_port`=1. If `io_ok_i` is low, either port operation issues no request, changes nothing and ends with done and no fault.
- R11: For every port-input element, a writability probe (`mreq_probe`=1) at the destination completes before the port read is issued.
- R12: `abort_i` during a request ends the instruction with `done_o` and `fault_o` both high for one cycle. The returned state is that of the last fully completed element, and the aborted transfer counts as not taken.
- R13: A request stalled by `mreq_ready`=0 keeps its address, direction and space unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Instruction request |
| start_ready | output | 1 | High while idle |
| op_i | input | 3 | 0 move, 1 compare, 2 store, 3 load, 4 scan, 5 port in, 6 port out |
| size_i | input | 2 | 0 byte, 1 word, 2 doubleword |
| rep_i | input | 2 | 0 none, 1 while equal, 2 while different |
| dir_i | input | 1 | 1 steps pointers downward |
| addr32_i | input | 1 | 1 selects 32-bit addressing |
| io_ok_i | input | 1 | Port access permitted |
| src_i | input | 32 | Source pointer |
| dst_i | input | 32 | Destination pointer |
| cnt_i | input | 32 | Element count |
| acc_i | input | 32 | Accumulator |
| port_i | input | 16 | Port number |
| flags_i | input | 4 | Flags before the instruction |
| mreq_valid | output | 1 | Request valid |
| mreq_ready | input | 1 | Request accepted (read data valid) |
| mreq_write | output | 1 | 1 write, 0 read or probe |
| mreq_port | output | 1 | Request targets port space |
| mreq_probe | output | 1 | Writability check, no data |
| mreq_addr | output | 32 | Memory address or port number |
| mreq_size | output | 2 | Element size code |
| mreq_wdata | output | 32 | Write data |
| mreq_rdata | input | 32 | Read data |
| abort_i | input | 1 | Fault on the current request |
| done_o | output | 1 | One-cycle end pulse |
| fault_o | output | 1 | End was caused by abort |
| src_o | output | 32 | Returned source pointer |
| dst_o | output | 32 | Returned destination pointer |
| cnt_o | output | 32 | Returned count |
| acc_o | output | 32 | Returned accumulator |
| flags_o | output | 4 | Returned flags |

## Verification
The abort can arrive in the same cycle as the acknowledge that would finish an element, for example on the write of the second element of a move. The unit must drop that element entirely rather than commit it. The bench provokes this by raising `abort_i` together with `mreq_ready` on a chosen acknowledge number, either a read or a write, and by suppressing the matching memory write in its model. It then judges the returned pointers, the count and the memory contents against a count of fully completed elements. The same final acknowledge also coincides with the decision to stop early on a compare, which the sweep exercises in both directions and at all three sizes.

// File: rtl/strop_pkg.sv
package strop_pkg;
  localparam int DW = 32;
  localparam int HW = 16;

  typedef enum logic [2:0] {
    OP_MOVE = 3'd0, OP_CMP = 3'd1, OP_STORE = 3'd2, OP_LOAD = 3'd3,
    OP_SCAN = 3'd4, OP_PIN = 3'd5, OP_POUT = 3'd6, OP_RSV = 3'd7
  } op_e;

  typedef enum logic [1:0] {RP_NONE = 2'd0, RP_EQ = 2'd1, RP_NE = 2'd2, RP_RSV = 2'd3} rep_e;

  typedef enum logic [2:0] {PH_IDLE, PH_SRC, PH_PROBE, PH_DST, PH_WR} ph_e;

  function automatic logic uses_src(op_e op);
    return op inside {OP_MOVE, OP_CMP, OP_LOAD, OP_POUT};
  endfunction

  function automatic logic uses_dst(op_e op);
    return op inside {OP_MOVE, OP_CMP, OP_STORE, OP_SCAN, OP_PIN};
  endfunction

  function automatic ph_e first_ph(op_e op);
    case (op)
      OP_STORE: return PH_WR;
      OP_SCAN:  return PH_DST;
      OP_PIN:   return PH_PROBE;
      default:  return PH_SRC;
    endcase
  endfunction

  function automatic logic [DW-1:0] elem_mask(logic [1:0] sz);
    case (sz)
      2'd0:    return DW'(32'h0000_00FF);
      2'd1:    return DW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [2:0] elem_bytes(logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/strop_step.sv
module strop_step #(
  parameter int XW = 32,
  parameter int LW = 16
) (
  input  logic [XW-1:0] ptr,
  input  logic [2:0]    nbytes,
  input  logic          down,
  input  logic          wide,
  output logic [XW-1:0] nxt
);
  logic [XW-1:0] delta, sum;
  always_comb begin
    delta = down ? (XW'(0) - XW'(nbytes)) : XW'(nbytes);
    sum   = ptr + delta;
    nxt   = wide ? sum : {ptr[XW-1:LW], sum[LW-1:0]};
  end
endmodule

// File: rtl/strop_flags.sv
module strop_flags #(
  parameter int XW = 32
) (
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  logic [1:0]    sz,
  output logic [3:0]    flg
);
  logic [XW-1:0] res;
  int msb;
  always_comb begin
    case (sz)
      2'd0:    msb = 7;
      2'd1:    msb = 15;
      default: msb = XW - 1;
    endcase
    res    = (a - b) & strop_pkg::elem_mask(sz);
    flg[0] = a < b;
    flg[1] = res == '0;
    flg[2] = res[msb];
    flg[3] = (a[msb] != b[msb]) && (res[msb] != a[msb]);
  end
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_valid,
  output logic          start_ready,
  input  logic [2:0]    op_i,
  input  logic [1:0]    size_i,
  input  logic [1:0]    rep_i,
  input  logic          dir_i,
  input  logic          addr32_i,
  input  logic          io_ok_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [DW-1:0] acc_i,
  input  logic [PW-1:0] port_i,
  input  logic [3:0]    flags_i,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic          mreq_write,
  output logic          mreq_port,
  output logic          mreq_probe,
  output logic [DW-1:0] mreq_addr,
  output logic [1:0]    mreq_size,
  output logic [DW-1:0] mreq_wdata,
  input  logic [DW-1:0] mreq_rdata,
  input  logic          abort_i,
  output logic          done_o,
  output logic          fault_o,
  output logic [DW-1:0] src_o,
  output logic [DW-1:0] dst_o,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] acc_o,
  output logic [3:0]    flags_o
);
  ph_e           ph;
  op_e           op_q;
  rep_e          rep_q;
  logic [1:0]    sz_q;
  logic          down_q, wide_q;
  logic [PW-1:0] port_q;
  logic [DW-1:0] r_src, r_dst, r_cnt, r_acc, s_val;
  logic [3:0]    r_flg, flg_new;
  logic          done_q, fault_q;

  logic [DW-1:0] mask, src_elem, dst_elem, src_nxt, dst_nxt, cnt_nxt, cnt_in_m;
  logic [2:0]    nb;
  logic          last_ph, is_cmp, same, stop, in_skip;

  // element arithmetic
  strop_step #(.XW(DW), .LW(HW)) u_src_step (
    .ptr(r_src), .nbytes(nb), .down(down_q), .wide(wide_q), .nxt(src_nxt));
  strop_step #(.XW(DW), .LW(HW)) u_dst_step (
    .ptr(r_dst), .nbytes(nb), .down(down_q), .wide(wide_q), .nxt(dst_nxt));
  strop_step #(.XW(DW), .LW(HW)) u_cnt_step (
    .ptr(r_cnt), .nbytes(3'd1), .down(1'b1), .wide(wide_q), .nxt(cnt_nxt));
  strop_flags #(.XW(DW)) u_flags (
    .a(src_elem), .b(dst_elem), .sz(sz_q), .flg(flg_new));

  always_comb begin
    mask     = elem_mask(sz_q);
    nb       = elem_bytes(sz_q);
    src_elem = (op_q == OP_STORE || op_q == OP_SCAN) ? (r_acc & mask) : s_val;
    dst_elem = mreq_rdata & mask;
    is_cmp   = (op_q == OP_CMP) || (op_q == OP_SCAN);
    same     = src_elem == dst_elem;
    last_ph  = (ph == PH_DST) || (ph == PH_WR) || (ph == PH_SRC && op_q == OP_LOAD);
    stop     = (rep_q == RP_NONE)
            || ((wide_q ? cnt_nxt : {{(DW-HW){1'b0}}, cnt_nxt[HW-1:0]}) == '0)
            || (is_cmp && rep_q == RP_EQ && !same)
            || (is_cmp && rep_q == RP_NE && same);
    cnt_in_m = addr32_i ? cnt_i : {{(DW-HW){1'b0}}, cnt_i[HW-1:0]};
    in_skip  = (rep_i != 2'd0 && cnt_in_m == '0)
            || ((op_i == 3'd5 || op_i == 3'd6) && !io_ok_i);
  end

  // request channel
  always_comb begin
    mreq_valid = ph != PH_IDLE;
    mreq_write = ph == PH_WR;
    mreq_probe = ph == PH_PROBE;
    mreq_port  = (ph == PH_SRC && op_q == OP_PIN) || (ph == PH_WR && op_q == OP_POUT);
    mreq_size  = sz_q;
    mreq_wdata = src_elem;
    if (mreq_port)
      mreq_addr = DW'(port_q);
    else if (ph == PH_SRC)
      mreq_addr = wide_q ? r_src : {{(DW-HW){1'b0}}, r_src[HW-1:0]};
    else
      mreq_addr = wide_q ? r_dst : {{(DW-HW){1'b0}}, r_dst[HW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; op_q <= OP_MOVE; rep_q <= RP_NONE; sz_q <= '0;
      down_q <= 1'b0; wide_q <= 1'b0; port_q <= '0;
      r_src <= '0; r_dst <= '0; r_cnt <= '0; r_acc <= '0; r_flg <= '0; s_val <= '0;
      done_q <= 1'b0; fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      if (ph == PH_IDLE) begin
        if (start_valid) begin
          op_q <= op_e'(op_i); rep_q <= rep_e'(rep_i); sz_q <= size_i;
          down_q <= dir_i; wide_q <= addr32_i; port_q <= port_i;
          r_src <= src_i; r_dst <= dst_i; r_cnt <= cnt_i; r_acc <= acc_i; r_flg <= flags_i;
          if (in_skip) done_q <= 1'b1;
          else         ph <= first_ph(op_e'(op_i));
        end
      end else if (abort_i) begin
        ph      <= PH_IDLE;
        done_q  <= 1'b1;
        fault_q <= 1'b1;
      end else if (mreq_ready) begin
        case (ph)
          PH_PROBE: ph <= PH_SRC;
          PH_SRC: begin
            s_val <= mreq_rdata & mask;
            if (op_q != OP_LOAD) ph <= (op_q == OP_CMP) ? PH_DST : PH_WR;
          end
          default: ;
        endcase
        if (last_ph) begin
          if (uses_src(op_q)) r_src <= src_nxt;
          if (uses_dst(op_q)) r_dst <= dst_nxt;
          if (rep_q != RP_NONE) r_cnt <= cnt_nxt;
          if (op_q == OP_LOAD) begin
            case (sz_q)
              2'd0:    r_acc[7:0]  <= mreq_rdata[7:0];
              2'd1:    r_acc[15:0] <= mreq_rdata[15:0];
              default: r_acc       <= mreq_rdata;
            endcase
          end
          if (stop && is_cmp) r_flg <= flg_new;
          if (stop) begin
            ph     <= PH_IDLE;
            done_q <= 1'b1;
          end else begin
            ph <= first_ph(op_q);
          end
        end
      end
    end
  end

  assign start_ready = ph == PH_IDLE;
  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign src_o   = r_src;
  assign dst_o   = r_dst;
  assign cnt_o   = r_cnt;
  assign acc_o   = r_acc;
  assign flags_o = r_flg;

  // assertions
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready && !abort_i |=> mreq_valid && $stable(mreq_addr)
      && $stable(mreq_write) && $stable(mreq_port)); // R13
  AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> done_o && !mreq_valid); // R12
  AST_PROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && mreq_port && !mreq_write |->
      $past(mreq_valid && (mreq_probe || (mreq_port && !mreq_write)))); // R11
  AST_ZERO_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready && rep_i != 2'd0 && cnt_in_m == '0 |=>
      done_o && !fault_o && !mreq_valid); // R4
  AST_FLAGS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags_o) && !$past(start_valid && start_ready) |-> done_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> !mreq_valid); // R1
endmodule

// File: tb/strop_seq_tb.sv
module strop_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0, start_ready;
  logic [2:0] op_i = '0; logic [1:0] size_i = '0, rep_i = '0;
  logic dir_i = 1'b0, addr32_i = 1'b0, io_ok_i = 1'b1;
  logic [31:0] src_i = '0, dst_i = '0, cnt_i = '0, acc_i = '0;
  logic [15:0] port_i = '0; logic [3:0] flags_i = '0;
  logic mreq_valid, mreq_ready = 1'b0, mreq_write, mreq_port, mreq_probe;
  logic [31:0] mreq_addr, mreq_wdata, mreq_rdata = '0; logic [1:0] mreq_size;
  logic abort_i = 1'b0, done_o, fault_o;
  logic [31:0] src_o, dst_o, cnt_o, acc_o; logic [3:0] flags_o;

  strop_seq u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  logic [7:0] mem [MW]; logic [7:0] shd [MW];
  logic [31:0] plog [16]; logic [31:0] elog [16];
  int pn, en, pr_seq, ack_no, ab_at, wait_c, hold_bad, probe_bad;
  logic probe_ok, hold_pend; logic [31:0] h_addr; logic h_wr, h_port;
  logic [31:0] e_src, e_dst, e_cnt, e_acc; logic [3:0] e_flg; logic e_fault;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pdata(input logic [15:0] p, input int seq);
    return {p, 16'h0} ^ (32'h9E37_79B9 * 32'(seq + 1));
  endfunction
  function automatic logic [31:0] ea(input logic [31:0] p, input logic w);
    return w ? p : {16'h0, p[15:0]};
  endfunction
  function automatic logic [31:0] stp(input logic [31:0] p, input int nb, input logic d, input logic w);
    logic [31:0] t = d ? p - 32'(nb) : p + 32'(nb);
    return w ? t : {p[31:16], t[15:0]};
  endfunction
  function automatic logic [31:0] msk(input int sz);
    return sz == 0 ? 32'hFF : (sz == 1 ? 32'hFFFF : 32'hFFFF_FFFF);
  endfunction
  function automatic logic [3:0] fref(input logic [31:0] s, input logic [31:0] d, input int sz);
    int b = 8 << sz; logic [31:0] r = (s - d) & msk(sz);
    return {(s[b-1] != d[b-1]) && (r[b-1] != s[b-1]), r[b-1], r == 0, s < d};
  endfunction
  function automatic logic [31:0] rdm(input logic [31:0] a, input int nb);
    logic [31:0] v = '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = mem[(a + 32'(i)) & 32'hFFF];
    return v;
  endfunction
  function automatic logic [31:0] rds(input logic [31:0] a, input int nb);
    logic [31:0] v = '0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = shd[(a + 32'(i)) & 32'hFFF];
    return v;
  endfunction
  task automatic wrs(input logic [31:0] a, input int nb, input logic [31:0] v);
    for (int i = 0; i < nb; i++) shd[(a + 32'(i)) & 32'hFFF] = v[8*i +: 8];
  endtask

  // memory and port responder: decisions made at negedge, transfer at next posedge
  always @(negedge clk) begin
    if (hold_pend && mreq_valid &&
        (mreq_addr !== h_addr || mreq_write !== h_wr || mreq_port !== h_port)) hold_bad++;
    mreq_ready = 1'b0; abort_i = 1'b0;
    if (mreq_valid) begin
      if (wait_c != 0) wait_c--;
      else begin
        mreq_ready = 1'b1;
        if (ack_no == ab_at) abort_i = 1'b1;
        if (mreq_probe) probe_ok = 1'b1;
        else if (mreq_port && !mreq_write) begin
          if (!probe_ok) probe_bad++;
          probe_ok = 1'b0;
          mreq_rdata = pdata(mreq_addr[15:0], pr_seq); pr_seq++;
        end else if (mreq_port) begin
          if (!abort_i && pn < 16) begin plog[pn] = mreq_wdata; pn++; end
        end else if (mreq_write) begin
          if (!abort_i)
            for (int i = 0; i < (1 << mreq_size); i++)
              mem[(mreq_addr + 32'(i)) & 32'hFFF] = mreq_wdata[8*i +: 8];
        end else mreq_rdata = rdm(mreq_addr, 1 << mreq_size);
        ack_no++;
        wait_c = ack_no % 3;
      end
    end
    hold_pend = mreq_valid && !mreq_ready;
    h_addr = mreq_addr; h_wr = mreq_write; h_port = mreq_port;
  end

  // reference behaviour from the requirements; lim = elements allowed before abort
  task automatic model(input int op, sz, rep, input logic d, w, input logic [31:0] s0, d0, c0, a0,
                       input logic [15:0] pt, input logic ok, input int lim);
    int nb = 1 << sz; int n = 0; int seq = 0; logic [31:0] sv, dv, m; logic stop;
    logic us = op inside {0, 1, 3, 6}; logic ud = op inside {0, 1, 2, 4, 5};
    m = msk(sz);
    e_src = s0; e_dst = d0; e_cnt = c0; e_acc = a0; e_flg = 4'b0101; e_fault = 1'b0; en = 0;
    if (rep != 0 && ea(c0, w) == 0) return;
    if ((op == 5 || op == 6) && !ok) return;
    forever begin
      if (n == lim) begin e_fault = 1'b1; break; end
      sv = 0; dv = 0;
      case (op)
        0: begin sv = rds(ea(e_src, w), nb); wrs(ea(e_dst, w), nb, sv); end
        1: begin sv = rds(ea(e_src, w), nb); dv = rds(ea(e_dst, w), nb); end
        2: begin sv = e_acc & m; wrs(ea(e_dst, w), nb, sv); end
        3: begin dv = rds(ea(e_src, w), nb); e_acc = (e_acc & ~m) | dv; end
        4: begin sv = e_acc & m; dv = rds(ea(e_dst, w), nb); end
        5: begin sv = pdata(pt, seq) & m; seq++; wrs(ea(e_dst, w), nb, sv); end
        default: begin sv = rds(ea(e_src, w), nb); elog[en] = sv; en++; end
      endcase
      if (us) e_src = stp(e_src, nb, d, w);
      if (ud) e_dst = stp(e_dst, nb, d, w);
      n++;
      if (rep == 0) stop = 1'b1;
      else begin
        e_cnt = stp(e_cnt, 1, 1'b1, w);
        stop = ea(e_cnt, w) == 0 || ((op == 1 || op == 4) &&
               ((rep == 1 && sv != dv) || (rep == 2 && sv == dv)));
      end
      if (stop) begin
        if (op == 1 || op == 4) e_flg = fref(sv, dv, sz);
        break;
      end
    end
  endtask

  task automatic run(input int op, sz, rep, input logic d, w, input logic [31:0] s0, d0, c0, a0,
                     input logic [15:0] pt, input logic ok, input int abat, input int lim);
    int cyc = 0; int mism = 0; logic busy_ready = 1'b0;
    for (int i = 0; i < MW; i++) shd[i] = mem[i];
    pn = 0; pr_seq = 0; ack_no = 0; ab_at = abat; wait_c = 1; probe_ok = 1'b0;
    hold_bad = 0; probe_bad = 0;
    model(op, sz, rep, d, w, s0, d0, c0, a0, pt, ok, lim);
    @(negedge clk);
    chk("R1 ready while idle", {31'b0, start_ready}, 32'd1);
    op_i = 3'(op); size_i = 2'(sz); rep_i = 2'(rep); dir_i = d; addr32_i = w; io_ok_i = ok;
    src_i = s0; dst_i = d0; cnt_i = c0; acc_i = a0; port_i = pt; flags_i = 4'b0101;
    start_valid = 1'b1;
    @(negedge clk);
    start_valid = 1'b0;
    while (!done_o && cyc < 5000) begin
      if (start_ready) busy_ready = 1'b1;
      @(negedge clk); cyc++;
    end
    chk("R1 done seen", {31'b0, done_o}, 32'd1);
    chk("R1 ready low while busy", {31'b0, busy_ready}, 32'd0);
    chk(w ? "R2 source pointer" : "R3 source pointer 16-bit", src_o, e_src);
    chk(w ? "R2 destination pointer" : "R3 destination pointer 16-bit", dst_o, e_dst);
    chk((op == 1 || op == 4) ? "R6 count" : "R5 count", cnt_o, e_cnt);
    chk("R9 accumulator", acc_o, e_acc);
    chk("R8 flags", {28'b0, flags_o}, {28'b0, e_flg});
    chk("R12 fault", {31'b0, fault_o}, {31'b0, e_fault});
    for (int i = 0; i < MW; i++) if (mem[i] !== shd[i]) mism++;
    chk("R7 memory contents", 32'(mism), 32'd0);
    chk("R10 port writes", 32'(pn), 32'(en));
    for (int i = 0; i < en && i < pn; i++) chk("R10 port data", plog[i], elog[i]);
    if (op == 5) chk("R11 probe before port read", 32'(probe_bad), 32'd0);
    if (cyc > 0 && (cyc % 4) == 0) chk("R13 stalled request stable", 32'(hold_bad), 32'd0);
    @(negedge clk);
    chk("R1 done one cycle", {31'b0, done_o}, 32'd0);
  endtask

  task automatic fill(input int op);
    for (int i = 0; i < MW; i++) mem[i] = (op == 1 || op == 4) ? 8'h5A : 8'(i * 7 + 3);
  endtask

  initial begin
    logic [31:0] s0, d0, c0, a0;
    for (int i = 0; i < MW; i++) mem[i] = '0;
    hold_pend = 1'b0; probe_ok = 1'b0; ab_at = -1; wait_c = 0; ack_no = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'b0, start_ready}, 32'd1);
    chk("R1 reset no request", {31'b0, mreq_valid}, 32'd0);
    chk("R1 reset done", {31'b0, done_o}, 32'd0);
    rst_n = 1'b1;
    // sweep: every operation, size, prefix, direction and address size
    for (int op = 0; op < 7; op++)
      for (int sz = 0; sz < 3; sz++)
        for (int rep = 0; rep < 3; rep++)
          for (int d = 0; d < 2; d++)
            for (int w = 0; w < 2; w++) begin
              fill(op);
              s0 = w ? (d ? 32'h0001_0208 : 32'h0001_0200) : (d ? 32'h0004_0002 : 32'h0004_FFFE);
              d0 = w ? (d ? 32'h0001_0A08 : 32'h0001_0A00) : (d ? 32'h0009_0804 : 32'h0009_07F0);
              c0 = w ? 32'd3 : 32'h0002_0003;
              a0 = (op == 4) ? 32'h5A5A_5A5A : 32'h8BAD_F00D;
              mem[ea(stp(d0, 1 << sz, d[0], w[0]), w[0]) & 32'hFFF] = 8'h21;
              run(op, sz, rep, d[0], w[0], s0, d0, c0, a0, 16'h02E0 + 16'(op), 1'b1, -1, 1000);
            end
    // R10: port access refused
    fill(5); run(5, 1, 1, 1'b0, 1'b1, 32'h200, 32'hA00, 32'd3, 32'h1, 16'h60, 1'b0, -1, 1000);
    fill(6); run(6, 2, 0, 1'b0, 1'b1, 32'h200, 32'hA00, 32'd3, 32'h1, 16'h61, 1'b0, -1, 1000);
    // R4: count zero in the active address size
    fill(0); run(0, 0, 1, 1'b0, 1'b0, 32'h200, 32'hA00, 32'h0007_0000, 32'h1, 16'h0, 1'b1, -1, 1000);
    fill(4); run(4, 1, 2, 1'b1, 1'b1, 32'h200, 32'hA00, 32'd0, 32'h1, 16'h0, 1'b1, -1, 1000);
    // R12: abort on a read, on the final write of an element, and later
    fill(0); run(0, 2, 1, 1'b0, 1'b1, 32'h200, 32'hA00, 32'd4, 32'h1, 16'h0, 1'b1, 0, 0);
    fill(0); run(0, 2, 1, 1'b0, 1'b1, 32'h200, 32'hA00, 32'd4, 32'h1, 16'h0, 1'b1, 3, 1);
    fill(0); run(0, 1, 2, 1'b1, 1'b0, 32'h3_0004, 32'h3_0A00, 32'd4, 32'h1, 16'h0, 1'b1, 6, 3);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=%0d exp=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule